// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM of 512K bytes. The host presents one request at a time, either a byte write or a byte read, with a 19-bit address. The controller sequences the active-low chip select, write enable and output enable lines of the memory. It holds address and write data in registers while the memory samples them. For a read it returns the byte with a one-cycle valid pulse.

All minimum intervals are given as nanosecond parameters together with the clock period. They are rounded up to whole cycles. With the default 10 ns period this gives a 4-cycle write strobe, a 6-cycle write occupancy, a 6-cycle read access and a 2-cycle bus turnaround after a read. Output enable stays high during writes. The controller drives the shared data lines only after the memory's output-disable window has passed.

Top module: `sram_ctl`

## Requirements
- R1: While reset is low and right after it, busy_o and rvalid_o are 0, mem_cs_n_o, mem_we_n_o and mem_oe_n_o are 1, and mem_dq_oe_o is 0.
- R2: A request (req_i high at a clock edge) is accepted only when busy_o is 0. busy_o is 1 from the next cycle on. A request raised while busy_o is 1 has no effect on the memory.
- R3: In a write, mem_cs_n_o falls in the first busy cycle while mem_we_n_o is still 1. mem_we_n_o is then 0 for exactly 4 cycles (40 ns rounded up), always together with mem_cs_n_o at 0. mem_oe_n_o stays 1 through the whole write.
- R4: mem_addr_o and mem_dq_o are loaded at acceptance and do not change while mem_cs_n_o is 0 or mem_dq_oe_o is 1. The write byte is driven from the cycle mem_cs_n_o falls, at least 25 ns before mem_we_n_o rises, until the last busy cycle of the write. Whenever busy_o is 0, all strobes are 1 and mem_dq_oe_o is 0.
- R5: A write keeps busy_o high for exactly 6 cycles: 55 ns rounded up, and never less than the strobe plus one setup and one tail cycle.
- R6: In a read, mem_cs_n_o and mem_oe_n_o are 0 for exactly 6 cycles (55 ns rounded up) with mem_we_n_o at 1 and mem_dq_oe_o at 0. mem_dq_i is captured on the edge that ends this count. rvalid_o is then 1 for exactly one cycle, with the byte on rdata_o.
- R7: After a read, busy_o stays 1 for 2 more cycles (20 ns output-disable time rounded up), so a read occupies 8 cycles. mem_dq_oe_o never rises unless mem_oe_n_o has been 1 for at least 2 cycles, so the two sides never drive the bus at once.
- R8: rdata_o keeps its value until the next read completes. Writes do not change it.
- R9: A byte written to an address is returned by a later read of that address. Other addresses keep their contents, and addresses never written read as the memory holds them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request, taken when busy_o is 0 |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 19 | Byte address |
| wdata_i | input | 8 | Write byte |
| busy_o | output | 1 | Access in progress |
| rdata_o | output | 8 | Last read byte |
| rvalid_o | output | 1 | One-cycle pulse with new read byte |
| mem_addr_o | output | 19 | Memory address lines |
| mem_cs_n_o | output | 1 | Memory chip select, active low |
| mem_we_n_o | output | 1 | Memory write enable, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_dq_o | output | 8 | Data toward memory |
| mem_dq_oe_o | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 8 | Data from memory |

## Verification
Writes and reads are run at the lowest and highest address, with bytes 00, FF and alternating bit patterns. This separates swapped or truncated address and data paths. A read of a never-written address and an overwrite followed by a read-back show that the stored byte is the latest one and that neighbours are untouched. The memory model returns inverted data until the full access time has elapsed, so sampling even one cycle early is caught. Further directed cases cover a request raised in mid-access, which must not reach the memory, and a write issued right after a read, which exposes any drive overlap during turnaround.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WPUL,
    ST_WTAIL,
    ST_RACC,
    ST_RTURN
  } st_e;

  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (load_i) cnt_q <= len_i - CNT_W'(1);
    else if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int CNT_W    = 3,
  parameter int WP_CYC   = 4,
  parameter int TAIL_CYC = 1,
  parameter int RD_CYC   = 6,
  parameter int TA_CYC   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             done_i,
  output st_e              state_o,
  output st_e              next_o,
  output logic             load_o,
  output logic [CNT_W-1:0] len_o,
  output logic             accept_o,
  output logic             capture_o
);
  st_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_i) state_d = we_i ? ST_WSET : ST_RACC;
      ST_WSET:  if (done_i) state_d = ST_WPUL;
      ST_WPUL:  if (done_i) state_d = ST_WTAIL;
      ST_WTAIL: if (done_i) state_d = ST_IDLE;
      ST_RACC:  if (done_i) state_d = ST_RTURN;
      ST_RTURN: if (done_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    case (state_d)
      ST_WPUL:  len_o = CNT_W'(WP_CYC);
      ST_WTAIL: len_o = CNT_W'(TAIL_CYC);
      ST_RACC:  len_o = CNT_W'(RD_CYC);
      ST_RTURN: len_o = CNT_W'(TA_CYC);
      default:  len_o = CNT_W'(1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else state_q <= state_d;
  end

  assign load_o    = (state_d != state_q);
  assign accept_o  = (state_q == ST_IDLE) && req_i;
  assign capture_o = (state_q == ST_RACC) && done_i;
  assign state_o   = state_q;
  assign next_o    = state_d;
endmodule

// File: rtl/sram_ctl_io.sv
module sram_ctl_io
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  st_e               next_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_cs_n_o,
  output logic              mem_we_n_o,
  output logic              mem_oe_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  strobe_t strb_d, strb_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic rvalid_q;

  // strobes registered from the next state so the pins never glitch
  always_comb begin
    strb_d = STROBE_IDLE;
    case (next_i)
      ST_WSET:  begin strb_d.cs_n = 1'b0; strb_d.dq_oe = 1'b1; end
      ST_WPUL:  begin strb_d.cs_n = 1'b0; strb_d.we_n = 1'b0; strb_d.dq_oe = 1'b1; end
      ST_WTAIL: strb_d.dq_oe = 1'b1;
      ST_RACC:  begin strb_d.cs_n = 1'b0; strb_d.oe_n = 1'b0; end
      default:  strb_d = STROBE_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_q   <= STROBE_IDLE;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      strb_q   <= strb_d;
      rvalid_q <= capture_i;
      if (accept_i) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (capture_i) rdata_q <= mem_dq_i;
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_cs_n_o  = strb_q.cs_n;
  assign mem_we_n_o  = strb_q.we_n;
  assign mem_oe_n_o  = strb_q.oe_n;
  assign mem_dq_oe_o = strb_q.dq_oe;
  assign mem_dq_o    = wdata_q;
  assign rdata_o     = rdata_q;
  assign rvalid_o    = rvalid_q;
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 8,
  parameter int T_CLK_NS = 10,
  parameter int T_WP_NS  = 40,
  parameter int T_WC_NS  = 55,
  parameter int T_RD_NS  = 55,
  parameter int T_HZ_NS  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_cs_n_o,
  output logic              mem_we_n_o,
  output logic              mem_oe_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int WP_CYC   = (T_WP_NS + T_CLK_NS - 1) / T_CLK_NS;
  localparam int WC_CYC   = (T_WC_NS + T_CLK_NS - 1) / T_CLK_NS;
  localparam int RD_RAW   = (T_RD_NS + T_CLK_NS - 1) / T_CLK_NS;
  localparam int HZ_RAW   = (T_HZ_NS + T_CLK_NS - 1) / T_CLK_NS;
  localparam int TAIL_RAW = WC_CYC - WP_CYC - 1;
  localparam int TAIL_CYC = (TAIL_RAW < 1) ? 1 : TAIL_RAW;
  localparam int RD_CYC   = (RD_RAW < 1) ? 1 : RD_RAW;
  localparam int TA_CYC   = (HZ_RAW < 1) ? 1 : HZ_RAW;
  localparam int MAX_A    = (WP_CYC > RD_CYC) ? WP_CYC : RD_CYC;
  localparam int MAX_B    = (TAIL_CYC > TA_CYC) ? TAIL_CYC : TA_CYC;
  localparam int MAX_LEN  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W    = $clog2(MAX_LEN + 1);

  st_e state, next;
  logic load, done, accept, capture;
  logic [CNT_W-1:0] len;

  sram_ctl_seq #(
    .CNT_W(CNT_W), .WP_CYC(WP_CYC), .TAIL_CYC(TAIL_CYC),
    .RD_CYC(RD_CYC), .TA_CYC(TA_CYC)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .done_i(done),
    .state_o(state), .next_o(next), .load_o(load), .len_o(len),
    .accept_o(accept), .capture_o(capture)
  );

  sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .len_i(len), .done_o(done)
  );

  sram_ctl_io #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_io (
    .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(accept), .addr_i(addr_i),
    .wdata_i(wdata_i), .next_i(next), .capture_i(capture), .mem_dq_i(mem_dq_i),
    .mem_addr_o(mem_addr_o), .mem_cs_n_o(mem_cs_n_o), .mem_we_n_o(mem_we_n_o),
    .mem_oe_n_o(mem_oe_n_o), .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe_o),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  assign busy_o = (state != ST_IDLE);
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 8,
  parameter int T_CLK_NS = 10,
  parameter int T_WP_NS  = 40,
  parameter int T_RD_NS  = 55,
  parameter int T_HZ_NS  = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              busy_o,
  input logic              rvalid_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_cs_n_o,
  input logic              mem_we_n_o,
  input logic              mem_oe_n_o,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe_o
);
  localparam int WP_CYC = (T_WP_NS + T_CLK_NS - 1) / T_CLK_NS;
  localparam int RD_CYC = (T_RD_NS + T_CLK_NS - 1) / T_CLK_NS;
  localparam int TA_CYC = (T_HZ_NS + T_CLK_NS - 1) / T_CLK_NS;

  logic [7:0] we_lo_cnt, oe_lo_cnt, oe_hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_lo_cnt <= '0;
      oe_lo_cnt <= '0;
      oe_hi_cnt <= 8'hff;
    end else begin
      we_lo_cnt <= mem_we_n_o ? 8'd0 : ((we_lo_cnt == 8'hff) ? we_lo_cnt : we_lo_cnt + 8'd1);
      oe_lo_cnt <= mem_oe_n_o ? 8'd0 : ((oe_lo_cnt == 8'hff) ? oe_lo_cnt : oe_lo_cnt + 8'd1);
      oe_hi_cnt <= !mem_oe_n_o ? 8'd0 : ((oe_hi_cnt == 8'hff) ? oe_hi_cnt : oe_hi_cnt + 8'd1);
    end
  end

  AST_BUSY_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !busy_o |=> busy_o);  // R2
  AST_WE_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> !mem_cs_n_o);  // R3
  AST_OE_OFF_IN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> mem_oe_n_o && mem_dq_oe_o);  // R3
  AST_WP_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> (we_lo_cnt >= 8'(WP_CYC)));  // R3
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_cs_n_o && $past(!mem_cs_n_o) |-> $stable(mem_addr_o));  // R4
  AST_DATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o && $past(mem_dq_oe_o) |-> $stable(mem_dq_o));  // R4
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> mem_cs_n_o && mem_we_n_o && mem_oe_n_o && !mem_dq_oe_o);  // R4
  AST_RD_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (oe_lo_cnt >= 8'(RD_CYC)));  // R6
  AST_RVALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);  // R6
  AST_BUS_TURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_n_o && (oe_hi_cnt >= 8'(TA_CYC)));  // R7
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> $stable(rdata_o));  // R8
endmodule

bind sram_ctl sram_ctl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_CLK_NS(T_CLK_NS),
  .T_WP_NS(T_WP_NS), .T_RD_NS(T_RD_NS), .T_HZ_NS(T_HZ_NS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .busy_o(busy_o),
  .rvalid_o(rvalid_o), .rdata_o(rdata_o), .mem_addr_o(mem_addr_o),
  .mem_cs_n_o(mem_cs_n_o), .mem_we_n_o(mem_we_n_o), .mem_oe_n_o(mem_oe_n_o),
  .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe_o)
);

// File: tb/sram_ctl_test.sv
module sram_ctl_test;
  localparam int WP = 4, WCYC = 6, RD = 6, RCYC = 8, DSET = 3;

  typedef struct packed {
    logic        w;
    logic [18:0] a;
    logic [7:0]  d;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 19'h00000, 8'hA5}, '{1'b1, 19'h7FFFF, 8'h3C}, '{1'b1, 19'h12345, 8'hFF},
    '{1'b1, 19'h00001, 8'h00}, '{1'b0, 19'h00000, 8'hA5}, '{1'b0, 19'h7FFFF, 8'h3C},
    '{1'b0, 19'h12345, 8'hFF}, '{1'b0, 19'h00001, 8'h00}, '{1'b1, 19'h00000, 8'h5A},
    '{1'b0, 19'h00000, 8'h5A}, '{1'b0, 19'h00002, 8'h00}, '{1'b1, 19'h00002, 8'h81},
    '{1'b0, 19'h00002, 8'h81}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [18:0] addr = '0;
  logic [7:0] wdata = '0;
  logic busy, rvalid, cs_n, we_n, oe_n, dq_oe;
  logic [7:0] rdata, dq_o, dq_i;
  logic [18:0] maddr;
  int total = 0, bad = 0;
  logic finished = 1'b0;

  always #2.5 clk = ~clk;

  sram_ctl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .busy_o(busy), .rdata_o(rdata), .rvalid_o(rvalid), .mem_addr_o(maddr),
    .mem_cs_n_o(cs_n), .mem_we_n_o(we_n), .mem_oe_n_o(oe_n), .mem_dq_o(dq_o),
    .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  // behavioural memory, evaluated mid-cycle
  logic [7:0] mem [logic [18:0]];
  int we_lo = 0, ds = 0, last_ds = 0, acc = 0, hold = 0;
  int err_wp = 0, err_ds = 0, err_bus = 0;
  logic prev_wact = 1'b0, prev_oe = 1'b0, mem_drv = 1'b0;
  logic [7:0] prev_dq = '0, last_dq = '0, mem_q = '0;
  logic [18:0] last_a = '0;

  function automatic logic [7:0] rd_mem(input logic [18:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      logic wact, ract;
      wact = !cs_n && !we_n;
      ract = !cs_n && !oe_n && we_n;
      if (dq_oe && prev_oe && dq_o == prev_dq) ds++;
      else ds = dq_oe ? 1 : 0;
      prev_oe = dq_oe;
      prev_dq = dq_o;
      if (wact) begin
        we_lo++; last_dq = dq_o; last_a = maddr; last_ds = ds;
        if (!dq_oe) err_ds++;
      end else if (prev_wact) begin
        if (we_lo < WP) err_wp++;
        if (last_ds < DSET) err_ds++;
        mem[last_a] = last_dq;
        we_lo = 0;
      end
      prev_wact = wact;
      if (ract) begin
        acc++; hold = 2;
        mem_q = (acc >= RD) ? rd_mem(maddr) : ~rd_mem(maddr);
      end else begin
        acc = 0;
        if (hold > 0) hold--;
      end
      mem_drv = ract || (hold > 0);
      if (dq_oe && mem_drv) err_bus++;
    end
  end

  assign dq_i = mem_drv ? mem_q : 8'h00;

  task automatic chk(input string rq, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic do_op(input logic w, input logic [18:0] a, input logic [7:0] d, input logic poke,
                       output int nb, output int nwe, output int noe, output int nrv,
                       output logic [7:0] rd, output logic first_ok, output logic bad_drv);
    nb = 0; nwe = 0; noe = 0; nrv = 0; rd = '0; bad_drv = 1'b0;
    while (busy) @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    first_ok = busy && !cs_n &&
               (w ? (we_n && oe_n && dq_oe) : (we_n && !oe_n && !dq_oe));
    while (busy) begin
      nb++;
      if (!we_n) nwe++;
      if (!oe_n) noe++;
      if (w && !oe_n) bad_drv = 1'b1;
      if (!w && dq_oe) bad_drv = 1'b1;
      if (rvalid) begin nrv++; rd = rdata; end
      if (poke && nb == 2) begin
        req = 1'b1; we = 1'b1; addr = 19'h00004; wdata = 8'hEE;
      end else req = 1'b0;
      @(negedge clk);
    end
    req = 1'b0;
    if (rvalid) begin nrv++; rd = rdata; end
  endtask

  initial begin
    int nb, nwe, noe, nrv;
    logic [7:0] rd;
    logic fok, bdrv;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 strobes in reset", int'({cs_n, we_n, oe_n, dq_oe, rvalid}), 5'b11100);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 strobes after reset", int'({busy, cs_n, we_n, oe_n, dq_oe, rvalid}), 6'b011100);

    for (int i = 0; i < NV; i++) begin
      do_op(VECS[i].w, VECS[i].a, VECS[i].d, 1'b0, nb, nwe, noe, nrv, rd, fok, bdrv);
      if (VECS[i].w) begin
        chk("R2/R3 first write cycle", int'(fok), 1);
        chk("R3 write strobe length", nwe, WP);
        chk("R3 oe high during write", int'(bdrv), 0);
        chk("R5 write occupancy", nb, WCYC);
      end else begin
        chk("R6 first read cycle", int'(fok), 1);
        chk("R6 oe low length", noe, RD);
        chk("R6 single rvalid", nrv, 1);
        chk("R6 no drive in read", int'(bdrv), 0);
        chk("R7 read occupancy", nb, RCYC);
        chk("R9 read back", int'(rd), int'(VECS[i].d));
      end
    end

    // R2: request raised mid-write must be dropped
    do_op(1'b1, 19'h00003, 8'h11, 1'b1, nb, nwe, noe, nrv, rd, fok, bdrv);
    chk("R2 occupancy with stray req", nb, WCYC);
    @(negedge clk);
    chk("R2 stray req not accepted", int'(busy), 0);
    do_op(1'b0, 19'h00004, 8'h00, 1'b0, nb, nwe, noe, nrv, rd, fok, bdrv);
    chk("R2 stray write absent", int'(rd), 8'h00);
    do_op(1'b0, 19'h00003, 8'h00, 1'b0, nb, nwe, noe, nrv, rd, fok, bdrv);
    chk("R9 neighbour written", int'(rd), 8'h11);

    // R8 rdata held across a write; also read directly followed by write (R7)
    do_op(1'b1, 19'h00003, 8'h77, 1'b0, nb, nwe, noe, nrv, rd, fok, bdrv);
    chk("R8 no rvalid on write", nrv, 0);
    chk("R8 rdata held", int'(rdata), 8'h11);
    do_op(1'b0, 19'h00003, 8'h00, 1'b0, nb, nwe, noe, nrv, rd, fok, bdrv);
    chk("R9 overwrite", int'(rd), 8'h77);
    chk("R4 idle quiet", int'({cs_n, we_n, oe_n, dq_oe}), 4'b1110);

    repeat (4) @(negedge clk);
    chk("R3 model write pulse errors", err_wp, 0);
    chk("R4 model data setup errors", err_ds, 0);
    chk("R7 model bus contention", err_bus, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule